// File: doc/BRIEF.md
# CRC-32 Zero-Advance Multiplier

This block moves a 32-bit CRC remainder forward as though a run of zero bits had been fed through the generator register. The run length can be 32, 64, 96 or 128 bits. The polynomial is 0x04C11DB7. The remainder is held most-significant-bit first: each zero-bit step shifts the register left and folds in the polynomial when the outgoing top bit is one. Advancing by P zero bits is the same as multiplying the remainder by the P-th power of the register's transition matrix.

In a wide incremental CRC datapath, the accumulated remainder is advanced by the full 128 bits on every beat except the last. On the final beat, the advance is picked to match how many 32-bit words that beat carries.

The four powers come from one chain of identical 32-bit advance stages wired in series. A 2-bit select taps the chain after one, two, three or four stages. The chosen result is registered, so it appears one clock after the request.

Top module: `crc_zero_adv`

## Requirements
- R1: With `in_valid` high and `in_sel` = 2'b00, the next clock loads `out_crc` with `in_crc` advanced by 32 zero bits.
- R2: With `in_valid` high and `in_sel` = 2'b01, the next clock loads `out_crc` with `in_crc` advanced by 64 zero bits.
- R3: With `in_valid` high and `in_sel` = 2'b10, the next clock loads `out_crc` with `in_crc` advanced by 96 zero bits.
- R4: With `in_valid` high and `in_sel` = 2'b11, the next clock loads `out_crc` with `in_crc` advanced by 128 zero bits.
- R5: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R6: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0 and `out_crc` is 0.
- R7: While `in_valid` is low, `out_crc` keeps its value whatever `in_sel` and `in_crc` carry.
- R8: An all-zero remainder advances to all zero, and a non-zero remainder never advances to zero.
- R9: The advance is linear: advancing `a ^ b` gives the XOR of the separate advances of `a` and `b`, for any select.
- R10: Advancing a result by 32 again gives the same value as advancing the original by 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request qualifier |
| in_sel | input | 2 | Advance length: 00=32, 01=64, 10=96, 11=128 zero bits |
| in_crc | input | 32 | Remainder to advance |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_crc | output | 32 | Advanced remainder |

## Verification
The assertions assume `in_valid` and `in_sel` are always known after reset, and that a result is read only in the cycle `out_valid` is high. The bench drives inputs just after the falling edge and keeps them stable through the next rising edge. During idle cycles it changes `in_sel` and `in_crc` freely, to show that these are ignored. The reference model clocks a serial register bit by bit, zero input only, and compares against the design on every cycle. Both all-zero and single-bit remainders are exercised.

// File: rtl/crc_adv_pkg.sv
package crc_adv_pkg;
    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

    // One zero-input step of an MSB-first generator register.
    function automatic logic [CRC_W-1:0] zstep(input logic [CRC_W-1:0] s,
                                               input logic [CRC_W-1:0] poly);
        zstep = {s[CRC_W-2:0], 1'b0} ^ (s[CRC_W-1] ? poly : '0);
    endfunction

    // Unrolled run of zero-input steps; reduces to a fixed XOR matrix.
    function automatic logic [CRC_W-1:0] zadvance(input logic [CRC_W-1:0] s,
                                                  input logic [CRC_W-1:0] poly,
                                                  input int steps);
        logic [CRC_W-1:0] v;
        v = s;
        for (int i = 0; i < steps; i++) v = zstep(v, poly);
        zadvance = v;
    endfunction
endpackage

// File: rtl/crc_adv_stage.sv
module crc_adv_stage
    import crc_adv_pkg::*;
#(
    parameter int W = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY,
    parameter int STEP_BITS = 32
) (
    input  logic [W-1:0] stage_in,
    output logic [W-1:0] stage_out
);
    always_comb begin
        stage_out = zadvance(stage_in, POLY, STEP_BITS);
    end
endmodule

// File: rtl/crc_adv_tap.sv
module crc_adv_tap #(
    parameter int W = 32,
    parameter int N_TAPS = 4,
    localparam int SEL_W = (N_TAPS > 1) ? $clog2(N_TAPS) : 1
) (
    input  logic [N_TAPS-1:0][W-1:0] taps,
    input  logic [SEL_W-1:0]         sel,
    output logic [W-1:0]             picked
);
    always_comb begin
        picked = taps[0];
        for (int i = 0; i < N_TAPS; i++) begin
            if (sel == SEL_W'(i)) picked = taps[i];
        end
    end
endmodule

// File: rtl/crc_zero_adv.sv
module crc_zero_adv
    import crc_adv_pkg::*;
#(
    parameter int W = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY,
    parameter int STEP_BITS = 32,
    parameter int N_STAGES = 4,
    localparam int SEL_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] in_sel,
    input  logic [W-1:0]     in_crc,
    output logic             out_valid,
    output logic [W-1:0]     out_crc
);
    // chain[0] is the input; chain[i+1] is the output of stage i.
    logic [N_STAGES:0][W-1:0]   chain;
    logic [N_STAGES-1:0][W-1:0] taps;
    logic [W-1:0]               picked;

    assign chain[0] = in_crc;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        crc_adv_stage #(.W(W), .POLY(POLY), .STEP_BITS(STEP_BITS)) stage_i (
            .stage_in (chain[g]),
            .stage_out(chain[g+1])
        );
        assign taps[g] = chain[g+1];
    end

    crc_adv_tap #(.W(W), .N_TAPS(N_STAGES)) tap_i (
        .taps  (taps),
        .sel   (in_sel),
        .picked(picked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_crc   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_crc <= picked;
        end
    end
endmodule

// File: rtl/crc_zero_adv_chk.sv
module crc_zero_adv_chk #(
    parameter int W = 32,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SEL_W-1:0] in_sel,
    input logic [W-1:0]     in_crc,
    input logic             out_valid,
    input logic [W-1:0]     out_crc
);
    p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_crc));
    p_zero_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_crc == '0) |=> (out_crc == '0));
    p_nonzero_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_crc != '0) |=> (out_crc != '0));
    p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_crc == '0));
    p_sel_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !$isunknown(in_sel));
endmodule

bind crc_zero_adv crc_zero_adv_chk #(.W(W), .SEL_W(SEL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
    .in_crc(in_crc), .out_valid(out_valid), .out_crc(out_crc)
);

// File: tb/crc_zero_adv_tb_top.sv
`timescale 1ns/1ps
module crc_zero_adv_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_sel = 2'b00;
    logic [31:0] in_crc = '0;
    logic        out_valid;
    logic [31:0] out_crc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        exp_v = 1'b0;
    logic [31:0] exp_c = '0;
    logic [31:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    crc_zero_adv dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
        .in_crc(in_crc), .out_valid(out_valid), .out_crc(out_crc)
    );

    // Serial reference: clock a bit-wide register k times with zero input.
    function automatic logic [31:0] ref_adv(input logic [31:0] s, input int k);
        logic [31:0] r = s;
        for (int i = 0; i < k; i++) begin
            logic top = r[31];
            r = r << 1;
            if (top) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    function automatic int sel_bits(input logic [1:0] sel);
        return 32 * (int'(sel) + 1);
    endfunction

    function automatic string sel_req(input logic [1:0] sel);
        case (sel)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    string last_req = "R7";

    // Compare against the model on this cycle, then drive the next request.
    task automatic step(input logic v, input logic [1:0] sel, input logic [31:0] crc);
        @(negedge clk);
        check("R5", {31'd0, out_valid}, {31'd0, exp_v});
        check(exp_v ? last_req : "R7", out_crc, exp_c);
        in_valid = v;
        in_sel   = sel;
        in_crc   = crc;
        exp_v    = v;
        if (v) begin
            exp_c    = ref_adv(crc, sel_bits(sel));
            last_req = sel_req(sel);
        end else begin
            last_req = "R7";
        end
    endtask

    initial begin
        logic [31:0] ra, rb, rab, r32, r64, a, b;
        repeat (3) @(negedge clk);
        check("R6", {31'd0, out_valid}, 32'd0);
        check("R6", out_crc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", {31'd0, out_valid}, 32'd0);
        check("R6", out_crc, 32'd0);

        // Single-bit remainders across all selects: R1..R4
        for (int s = 0; s < 4; s++) begin
            for (int b2 = 0; b2 < 32; b2 += 7) step(1'b1, 2'(s), 32'h1 << b2);
        end
        step(1'b1, 2'b11, 32'h8000_0000);
        // All-zero and all-ones remainders: R8
        for (int s = 0; s < 4; s++) step(1'b1, 2'(s), 32'h0);
        for (int s = 0; s < 4; s++) step(1'b1, 2'(s), 32'hFFFF_FFFF);
        // Idle cycles with changing inputs: R7
        for (int i = 0; i < 6; i++) step(1'b0, 2'(i), next_rand());
        // Random mix of valid and idle
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = next_rand();
            step(r[0] | r[1], r[3:2], next_rand());
        end
        step(1'b0, 2'b00, 32'h0);

        // R9 linearity and R10 composition, observed at the ports
        for (int s = 0; s < 4; s++) begin
            a = next_rand();
            b = next_rand();
            step(1'b1, 2'(s), a);
            step(1'b0, 2'(s), 32'h0);
            ra = out_crc;
            step(1'b1, 2'(s), b);
            step(1'b0, 2'(s), 32'h0);
            rb = out_crc;
            step(1'b1, 2'(s), a ^ b);
            step(1'b0, 2'(s), 32'h0);
            rab = out_crc;
            check("R9", rab, ra ^ rb);
        end
        a = next_rand();
        step(1'b1, 2'b00, a);
        step(1'b0, 2'b00, 32'h0);
        r32 = out_crc;
        step(1'b1, 2'b00, r32);
        step(1'b0, 2'b00, 32'h0);
        r64 = out_crc;
        step(1'b1, 2'b01, a);
        step(1'b0, 2'b00, 32'h0);
        check("R10", r64, out_crc);

        // Reset in the middle of traffic: R6
        step(1'b1, 2'b10, 32'hDEAD_BEEF);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R6", {31'd0, out_valid}, 32'd0);
        check("R6", out_crc, 32'd0);
        rst_n = 1'b1;
        exp_v = 1'b0;
        exp_c = '0;
        last_req = "R7";
        step(1'b0, 2'b00, 32'h0);
        step(1'b0, 2'b00, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule